// File: doc/BRIEF.md
# Clock Mode Control Sequencer

This block decides where the system clock comes from and how many clocks make up one machine cycle. It holds a small configuration register. That register holds a two-bit divide code, an enable for the frequency multiplier, a x2/x4 multiplier choice, a switch-back enable and a ring-oscillator select. The block applies the lockout rules that keep software from moving straight between two non-default clock modes. The real oscillators, the multiplier and the glitch-free clock mux sit outside; this block only drives their select lines.

A warm-up counter runs after every reset, after every stop-mode exit and whenever the multiplier is turned on. While it runs, the clock-ready flag stays low, and the multiplied clock cannot be selected. If ring select is set, a stop-mode exit runs the system from the ring oscillator until the warm-up ends; the block then hands the clock back to the crystal by itself. With switch-back enabled, an external-interrupt acknowledge or a detected serial start bit pulls the block out of the slow divide-by-1024 mode.

Top module: `clk_mode_seq`

## Requirements
- R1: The divide code maps to the source as follows: 00 selects the multiplier output (`clk_src` = 01); 10 selects the crystal at 4 clocks per machine cycle and 11 the crystal at 1024 (`clk_src` = 00). A running ring oscillator overrides both (`clk_src` = 10).
- R2: Any reset, and any stop-mode exit, sets the divide code to 10, clears clock-ready and restarts the warm-up count from zero. Reset also clears the multiplier enable, the x4 choice and switch-back. Ring select is cleared only when `rst_por` accompanies the reset.
- R3: A written divide code takes effect only if the old code or the new code is 10. A code of 01 is reserved and never accepted, and a rejected code leaves the old one in place.
- R4: A write that turns the multiplier enable on clears clock-ready at the same edge. Clock-ready then rises exactly WARMUP_CYCLES clocks later. The warm-up started by reset or by a stop exit behaves the same way.
- R5: A divide code of 00 is accepted only while clock-ready and the multiplier enable are both 1.
- R6: The multiplier enable changes by a write only while the divide code is 10 and the ring oscillator is not running. A stop-mode entry clears it.
- R7: The x4 choice (0 = 2x, 1 = 4x, on `mult_x4`) changes only while the multiplier enable is 0.
- R8: A stop-mode exit with ring select set raises the ring-active flag until the warm-up ends, and then drops it. While the flag is up, writes to ring select and any divide code other than 10 are ignored.
- R9: With switch-back enabled and the divide code at 11, an `ext_int_ack` or `serial_start` pulse forces the code to 10 at the next edge, and this overrides a write in the same cycle. With switch-back disabled, these pulses have no effect.
- R10: The register bits are: [1:0] divide code, [2] multiplier enable, [3] x4, [4] switch-back, [5] ring select, [6] clock-ready (read-only) and [7] ring-active (read-only). A rejected field leaves all other fields of the same write in force. `rd_data` always shows the state in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst | input | 1 | Synchronous reset, any kind, active high |
| rst_por | input | 1 | Marks the current reset as power-on |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| stop_enter | input | 1 | One-cycle pulse on stop-mode entry |
| stop_exit | input | 1 | One-cycle pulse on stop-mode exit |
| ext_int_ack | input | 1 | External interrupt acknowledge pulse |
| serial_start | input | 1 | Serial start-bit detect pulse |
| rd_data | output | 8 | Register read-back |
| clk_src | output | 2 | Clock source select: 00 crystal, 01 multiplier, 10 ring |
| div_code | output | 2 | Clocks-per-machine-cycle code in effect |
| mult_x4 | output | 1 | Multiplier factor: 0 = 2x, 1 = 4x |
| clk_ready | output | 1 | Warm-up complete |
| ring_active | output | 1 | System running from the ring oscillator |

## Verification
The assertions assume that reset is held for at least two clocks and that it is high at time zero with `rst_por` set, so that ring select starts from a known value. They also assume that stop entry and stop exit never pulse in the same cycle, and that no register write shares a cycle with a stop-mode pulse. The stimulus drives each pulse alone for one cycle between register writes and starts with a power-on reset held for three cycles. Switch-back pulses are the only events sent together with other activity.

// File: rtl/clkm_pkg.sv
package clkm_pkg;

    typedef enum logic [1:0] {
        DIV_MULT = 2'b00,
        DIV_RSVD = 2'b01,
        DIV_BY4  = 2'b10,
        DIV_BY1K = 2'b11
    } div_code_e;

    typedef enum logic [1:0] {
        SRC_XTAL = 2'b00,
        SRC_MULT = 2'b01,
        SRC_RING = 2'b10
    } clk_src_e;

    localparam int CFG_MUL_BIT  = 2;
    localparam int CFG_X4_BIT   = 3;
    localparam int CFG_SWB_BIT  = 4;
    localparam int CFG_RSEL_BIT = 5;

    typedef struct packed {
        div_code_e div;
        logic      mul_en;
        logic      x4;
        logic      swb;
        logic      ring_sel;
        logic      ready;
        logic      ring_act;
    } ctl_state_t;

endpackage

// File: rtl/clkm_warmup.sv
module clkm_warmup #(
    parameter int WARMUP_CYCLES = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic done_o
);
    localparam int CW = (WARMUP_CYCLES > 1) ? $clog2(WARMUP_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WARMUP_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          busy;
    } wu_state_t;

    wu_state_t wu_q, wu_d;

    assign done_o = wu_q.busy && (wu_q.cnt == LAST);

    always_comb begin
        wu_d = wu_q;
        if (start_i) begin
            wu_d.cnt  = '0;
            wu_d.busy = 1'b1;
        end else if (done_o) begin
            wu_d.busy = 1'b0;
        end else if (wu_q.busy) begin
            wu_d.cnt = wu_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wu_q.cnt  <= '0;
            wu_q.busy <= 1'b1;
        end else begin
            wu_q <= wu_d;
        end
    end
endmodule

// File: rtl/clkm_ctrl.sv
module clkm_ctrl
    import clkm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rst_por,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       stop_enter,
    input  logic       stop_exit,
    input  logic       ext_int_ack,
    input  logic       serial_start,
    input  logic       done_i,
    output logic       start_o,
    output ctl_state_t state_o
);
    ctl_state_t st_q, st_d;
    div_code_e  wdiv;
    logic       via_default;
    logic       div_ok;
    logic       start_d;

    assign wdiv        = div_code_e'(wr_data[1:0]);
    assign via_default = (st_q.div == DIV_BY4) || (wdiv == DIV_BY4);
    assign div_ok      = (wdiv != DIV_RSVD) && via_default
                       && !(st_q.ring_act && (wdiv != DIV_BY4))
                       && !((wdiv == DIV_MULT) && !(st_q.ready && st_q.mul_en));

    always_comb begin
        st_d    = st_q;
        start_d = 1'b0;
        if (wr_en) begin
            st_d.swb = wr_data[CFG_SWB_BIT];
            if (!st_q.mul_en)
                st_d.x4 = wr_data[CFG_X4_BIT];
            if (!st_q.ring_act)
                st_d.ring_sel = wr_data[CFG_RSEL_BIT];
            if ((st_q.div == DIV_BY4) && !st_q.ring_act
                && (wr_data[CFG_MUL_BIT] != st_q.mul_en)) begin
                st_d.mul_en = wr_data[CFG_MUL_BIT];
                start_d     = wr_data[CFG_MUL_BIT];
            end
            if (div_ok)
                st_d.div = wdiv;
        end
        if (st_q.swb && (st_q.div == DIV_BY1K) && (ext_int_ack || serial_start))
            st_d.div = DIV_BY4;
        if (stop_enter) begin
            st_d.mul_en = 1'b0;
            start_d     = 1'b0;
        end
        if (stop_exit) begin
            st_d.div      = DIV_BY4;
            st_d.ring_act = st_q.ring_sel;
            start_d       = 1'b1;
        end
        if (start_d) begin
            st_d.ready = 1'b0;
        end else if (done_i) begin
            st_d.ready    = 1'b1;
            st_d.ring_act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.div      <= DIV_BY4;
            st_q.mul_en   <= 1'b0;
            st_q.x4       <= 1'b0;
            st_q.swb      <= 1'b0;
            st_q.ring_sel <= rst_por ? 1'b0 : st_q.ring_sel;
            st_q.ready    <= 1'b0;
            st_q.ring_act <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o = start_d;
    assign state_o = st_q;
endmodule

// File: rtl/clkm_src_dec.sv
module clkm_src_dec
    import clkm_pkg::*;
(
    input  div_code_e div_i,
    input  logic      ring_act_i,
    output clk_src_e  src_o
);
    always_comb begin
        if (ring_act_i)
            src_o = SRC_RING;
        else if (div_i == DIV_MULT)
            src_o = SRC_MULT;
        else
            src_o = SRC_XTAL;
    end
endmodule

// File: rtl/clk_mode_seq.sv
module clk_mode_seq
    import clkm_pkg::*;
#(
    parameter int WARMUP_CYCLES = 65536
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rst_por,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       stop_enter,
    input  logic       stop_exit,
    input  logic       ext_int_ack,
    input  logic       serial_start,
    output logic [7:0] rd_data,
    output logic [1:0] clk_src,
    output logic [1:0] div_code,
    output logic       mult_x4,
    output logic       clk_ready,
    output logic       ring_active
);
    ctl_state_t st;
    logic       wu_start;
    logic       wu_done;
    clk_src_e   src;

    clkm_warmup #(.WARMUP_CYCLES(WARMUP_CYCLES)) u_warmup (
        .clk     (clk),
        .rst     (rst),
        .start_i (wu_start),
        .done_o  (wu_done)
    );

    clkm_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .rst_por      (rst_por),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .stop_enter   (stop_enter),
        .stop_exit    (stop_exit),
        .ext_int_ack  (ext_int_ack),
        .serial_start (serial_start),
        .done_i       (wu_done),
        .start_o      (wu_start),
        .state_o      (st)
    );

    clkm_src_dec u_src (
        .div_i      (st.div),
        .ring_act_i (st.ring_act),
        .src_o      (src)
    );

    assign rd_data     = {st.ring_act, st.ready, st.ring_sel, st.swb,
                          st.x4, st.mul_en, st.div};
    assign clk_src     = src;
    assign div_code    = st.div;
    assign mult_x4     = st.x4;
    assign clk_ready   = st.ready;
    assign ring_active = st.ring_act;
endmodule

// File: rtl/clk_mode_seq_chk.sv
module clk_mode_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       stop_exit,
    input logic       ext_int_ack,
    input logic       serial_start,
    input logic [7:0] rd_data,
    input logic [1:0] div_code,
    input logic       clk_ready,
    input logic       ring_active
);
    a_r2_stop_exit_default: assert property (@(posedge clk) disable iff (rst)
        stop_exit |=> (div_code == 2'b10) && !clk_ready);

    a_r3_no_reserved: assert property (@(posedge clk) disable iff (rst)
        div_code != 2'b01);

    a_r3_via_default: assert property (@(posedge clk) disable iff (rst)
        (div_code != $past(div_code)) |-> (($past(div_code) == 2'b10) || (div_code == 2'b10)));

    a_r5_mult_needs_ready: assert property (@(posedge clk) disable iff (rst)
        ((div_code == 2'b00) && ($past(div_code) != 2'b00)) |-> ($past(clk_ready) && $past(rd_data[2])));

    a_r4_enable_clears_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[2]) |-> !clk_ready);

    a_r6_enable_needs_default: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[2]) |-> (($past(div_code) == 2'b10) && !$past(ring_active)));

    a_r7_x4_locked: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_data[3]) |-> !$past(rd_data[2]));

    a_r8_ring_not_ready: assert property (@(posedge clk) disable iff (rst)
        ring_active |-> !clk_ready);

    a_r9_switch_back: assert property (@(posedge clk) disable iff (rst)
        (rd_data[4] && (div_code == 2'b11) && (ext_int_ack || serial_start)) |=> (div_code == 2'b10));
endmodule

bind clk_mode_seq clk_mode_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .stop_exit    (stop_exit),
    .ext_int_ack  (ext_int_ack),
    .serial_start (serial_start),
    .rd_data      (rd_data),
    .div_code     (div_code),
    .clk_ready    (clk_ready),
    .ring_active  (ring_active)
);

// File: tb/clk_mode_seq_bench.sv
module clk_mode_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rst_por = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       stop_enter = 1'b0;
    logic       stop_exit = 1'b0;
    logic       ext_int_ack = 1'b0;
    logic       serial_start = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] clk_src;
    logic [1:0] div_code;
    logic       mult_x4;
    logic       clk_ready;
    logic       ring_active;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 0;
    string cur_req = "R2";

    // behavioural reference state
    int m_div = 2, m_mul = 0, m_x4 = 0, m_swb = 0, m_rsel = 0;
    int m_rdy = 0, m_ract = 0, m_cnt = 0, m_busy = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_mode_seq #(.WARMUP_CYCLES(W)) u_clk_mode_seq (
        .clk(clk), .rst(rst), .rst_por(rst_por), .wr_en(wr_en), .wr_data(wr_data),
        .stop_enter(stop_enter), .stop_exit(stop_exit), .ext_int_ack(ext_int_ack),
        .serial_start(serial_start), .rd_data(rd_data), .clk_src(clk_src),
        .div_code(div_code), .mult_x4(mult_x4), .clk_ready(clk_ready),
        .ring_active(ring_active)
    );

    always @(posedge clk) begin
        int n_div, n_mul, n_x4, n_swb, n_rsel, n_rdy, n_ract, w;
        bit start, fin, accept;
        if (rst) begin
            m_div = 2; m_mul = 0; m_x4 = 0; m_swb = 0; m_rdy = 0; m_ract = 0;
            m_cnt = 0; m_busy = 1;
            if (rst_por) m_rsel = 0;
        end else begin
            n_div = m_div; n_mul = m_mul; n_x4 = m_x4; n_swb = m_swb;
            n_rsel = m_rsel; n_rdy = m_rdy; n_ract = m_ract;
            start = 0;
            fin = (m_busy == 1) && (m_cnt == W - 1);
            if (wr_en) begin
                n_swb = wr_data[4];
                if (m_mul == 0) n_x4 = wr_data[3];
                if (m_ract == 0) n_rsel = wr_data[5];
                if (m_div == 2 && m_ract == 0 && int'(wr_data[2]) != m_mul) begin
                    n_mul = wr_data[2];
                    start = wr_data[2];
                end
                w = wr_data[1:0];
                accept = (w != 1) && (m_div == 2 || w == 2);
                if (m_ract == 1 && w != 2) accept = 0;
                if (w == 0 && !(m_rdy == 1 && m_mul == 1)) accept = 0;
                if (accept) n_div = w;
            end
            if (m_swb == 1 && m_div == 3 && (ext_int_ack || serial_start)) n_div = 2;
            if (stop_enter) begin n_mul = 0; start = 0; end
            if (stop_exit) begin n_div = 2; n_ract = m_rsel; start = 1; end
            if (start) begin
                n_rdy = 0; m_cnt = 0; m_busy = 1;
            end else if (fin) begin
                n_rdy = 1; n_ract = 0; m_busy = 0;
            end else if (m_busy == 1) begin
                m_cnt = m_cnt + 1;
            end
            m_div = n_div; m_mul = n_mul; m_x4 = n_x4; m_swb = n_swb;
            m_rsel = n_rsel; m_rdy = n_rdy; m_ract = n_ract;
        end
    end

    function automatic logic [7:0] model_rd();
        return {m_ract[0], m_rdy[0], m_rsel[0], m_swb[0], m_x4[0], m_mul[0], m_div[1:0]};
    endfunction

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        int exp_src;
        if (!rst && !finished) begin
            exp_src = (m_ract == 1) ? 2 : ((m_div == 0) ? 1 : 0);
            n_checks++;
            if (rd_data !== model_rd() || clk_src !== 2'(exp_src) || div_code !== 2'(m_div)
                || mult_x4 !== m_x4[0] || clk_ready !== m_rdy[0] || ring_active !== m_ract[0]) begin
                n_fail++;
                $display("FAIL %s model compare: rd=%h src=%0d expected rd=%h src=%0d",
                         cur_req, rd_data, clk_src, model_rd(), exp_src);
            end
        end
    end

    task automatic expect8(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_stop_enter(); stop_enter = 1; @(negedge clk); stop_enter = 0; endtask
    task automatic pulse_stop_exit();  stop_exit = 1;  @(negedge clk); stop_exit = 0;  endtask
    task automatic pulse_ack();        ext_int_ack = 1; @(negedge clk); ext_int_ack = 0; endtask
    task automatic pulse_ser();        serial_start = 1; @(negedge clk); serial_start = 0; endtask

    task automatic do_reset(logic por);
        rst = 1; rst_por = por;
        repeat (3) @(negedge clk);
        rst = 0; rst_por = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0; rst_por = 0;
        cur_req = "R2";
        expect8("R2", rd_data, 8'h02);
        cur_req = "R4";
        repeat (W - 1) @(negedge clk);
        expect8("R4", {7'd0, clk_ready}, 8'h00);
        @(negedge clk);
        expect8("R4", {7'd0, clk_ready}, 8'h01);

        cur_req = "R1";
        wr(8'h03);
        expect8("R1", {div_code, clk_src}, {2'b11, 2'b00});
        cur_req = "R3";
        wr(8'h00);
        expect8("R3", {6'd0, div_code}, 8'h03);
        wr(8'h01);
        expect8("R3", {6'd0, div_code}, 8'h03);
        wr(8'h02);
        cur_req = "R5";
        wr(8'h00);
        expect8("R5", {6'd0, div_code}, 8'h02);

        cur_req = "R4";
        wr(8'h0E);
        expect8("R4", {7'd0, clk_ready}, 8'h00);
        repeat (W - 1) @(negedge clk);
        expect8("R4", {7'd0, clk_ready}, 8'h00);
        @(negedge clk);
        expect8("R4", {7'd0, clk_ready}, 8'h01);

        cur_req = "R7";
        wr(8'h06);
        expect8("R7", {7'd0, mult_x4}, 8'h01);
        cur_req = "R5";
        wr(8'h0C);
        expect8("R5", {div_code, clk_src}, {2'b00, 2'b01});
        cur_req = "R3";
        wr(8'h0F);
        expect8("R3", {6'd0, div_code}, 8'h00);
        cur_req = "R10";
        wr(8'h08);
        expect8("R10", rd_data, 8'h4C);

        cur_req = "R9";
        wr(8'h0E);
        wr(8'h1F);
        expect8("R9", {6'd0, div_code}, 8'h03);
        pulse_ack();
        expect8("R9", {6'd0, div_code}, 8'h02);
        wr(8'h1F);
        pulse_ser();
        expect8("R9", {6'd0, div_code}, 8'h02);
        wr(8'h0F);
        pulse_ack();
        expect8("R9", {6'd0, div_code}, 8'h03);
        // switch-back wins over a same-cycle write of 11
        wr(8'h1F);
        ext_int_ack = 1; wr(8'h1F); ext_int_ack = 0;
        expect8("R9", {6'd0, div_code}, 8'h02);

        cur_req = "R6";
        wr(8'h2E);
        pulse_stop_enter();
        expect8("R6", {7'd0, rd_data[2]}, 8'h00);
        cur_req = "R8";
        pulse_stop_exit();
        expect8("R8", {ring_active, clk_ready, 4'd0, clk_src}, {1'b1, 1'b0, 4'd0, 2'b10});
        wr(8'h0F);
        expect8("R8", {rd_data[5], 5'd0, div_code}, {1'b1, 5'd0, 2'b10});
        wr(8'h06);
        expect8("R6", {7'd0, rd_data[2]}, 8'h00);
        repeat (W) @(negedge clk);
        expect8("R8", {6'd0, ring_active, clk_ready}, 8'h01);
        expect8("R1", {6'd0, clk_src}, 8'h00);

        cur_req = "R2";
        wr(8'h23);
        do_reset(1'b0);
        expect8("R2", rd_data, 8'h22);
        do_reset(1'b1);
        expect8("R2", rd_data, 8'h02);
        repeat (W + 2) @(negedge clk);
        summary();
    end
endmodule